// File: doc/BRIEF.md
# System Configuration Register Block

This block is a word-addressed register file that collects board-level system control into one place. It is reached over a simple 32-bit bus with a 12-bit byte offset. Every access takes one cycle, and read data comes back combinationally in the cycle the access is presented. It holds the following:

- two general-purpose configuration words; the low byte of the second one drives eight LED outputs;
- three identification words whose values are fixed by parameters;
- a switch word that always reads as zero;
- a clock-lock word in which only the mask byte is writable.

The block also hosts an indirect configuration channel in front of three oscillator frequency registers. These registers cannot be reached directly on the bus. To reach one, software loads the outgoing-data word and then writes the control word with its start flag set. The control word carries a device index, a function code and a direction flag. The transaction finishes on the same clock edge as the control write. The channel state machine holds the outcome, and the status word reports it.

The channel state machine has three states:

- `CH_IDLE`: status reads 0.
- `CH_DONE`: status reads 1.
- `CH_FAULT`: status reads 3.

Its transitions all happen on a control write:

- `clear`: the start flag is 0. The next state is `CH_IDLE` from any state.
- `finish`: the start flag is 1, the function code is 1 and the device index is below 3. The next state is `CH_DONE`.
- `reject`: the start flag is 1 and the function code or device index is out of range. The next state is `CH_FAULT`.

Without a control write, the state is held.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, the registers read as follows:
  - control word: 0x00100000;
  - status word, general word 0 (offset 0x000), general word 1 (0x004), return-data (0x0A0) and outgoing-data (0x0A4): 0;
  - clock-lock word (0x100): 0xFFFF0001.
- R2: General word 0 and general word 1 are fully readable and writable. `led` always equals bits [7:0] of general word 1.
- R3: The following words ignore writes:
  - the switch word (0x00C), which reads 0;
  - offset 0x010, which reads parameter CFG4_VALUE;
  - offset 0xFF8, which reads AUX_ID_VALUE;
  - offset 0xFFC, which reads ID_VALUE.
- R4: The control word at 0x0A8 stores three fields: the device index in bits [11:0], the function code in bits [25:20] and the direction flag in bit 30. Bits [19:12], bits [29:26] and the start flag (bit 31) are never stored, so a write of 0xFFFFFFFF reads back as 0x43F00FFF.
- R5: Every write to the control word first clears the status word (0x0AC: bit 0 done, bit 1 error). A control write with start = 0 leaves the status at 0.
- R6: A control write is valid when start = 1, the function code is 1 and the device index is below 3. It yields status 1, and a status read in the next bus cycle already shows it.
- R7: A control write with start = 1 whose function code or device index is out of range yields status 3. It changes neither the oscillator registers nor the return-data word.
- R8: The oscillator registers reset to 50000000, 24576000 and 25000000 for devices 0, 1 and 2. A valid write (bit 30 = 1) copies the outgoing-data word into the addressed oscillator. A valid read (bit 30 = 0) copies the addressed oscillator into the return-data word.
- R9: In the clock-lock word, only bits [31:24] are writable. Bits [23:0] always read as 0xFF0001.
- R10: An access to an unmapped offset has three effects. A read returns 0, a write changes no register, and `bus_fault` is high while the access is presented. Address bits [1:0] are ignored in decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_sel is high and bus_write is low |
| bus_fault | output | 1 | High while an unmapped offset is accessed |
| led | output | 8 | LED drive, bits [7:0] of general word 1 |

## Verification
The hardest case to reach from the ports is the `reject` transition, because it must leave the hidden oscillator registers and the return-data word untouched. The oscillators can only be observed through further channel reads. The stimulus therefore sweeps all 64 function codes against device indices on both sides of the limit, checking status and return data after each one. It then writes distinct values into the oscillators, fires invalid writes, and reads every oscillator back through the channel so that it can be compared with a model kept in the bench.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned ADDR_W = 12;

    // control word fields
    localparam int unsigned DEV_LSB   = 0;
    localparam int unsigned DEV_W     = 12;
    localparam int unsigned FUNC_LSB  = 20;
    localparam int unsigned FUNC_W    = 6;
    localparam int unsigned WDIR_BIT  = 30;
    localparam int unsigned START_BIT = 31;

    localparam logic [WORD_W-1:0] CTRL_KEEP  = 32'h43F0_0FFF;
    localparam logic [WORD_W-1:0] CTRL_RESET = 32'h0010_0000;
    localparam logic [WORD_W-1:0] LOCK_RESET = 32'hFFFF_0001;
    localparam logic [WORD_W-1:0] LOCK_WMASK = 32'hFF00_0000;

    typedef enum logic [3:0] {
        RG_NONE, RG_GEN0, RG_GEN1, RG_SWITCH, RG_CFG4, RG_RTN, RG_OUT,
        RG_CTRL, RG_STAT, RG_LOCK, RG_AUXID, RG_ID
    } reg_id_e;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'b00,
        CH_DONE  = 2'b01,
        CH_FAULT = 2'b11
    } chan_state_e;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_id_e           id,
    output logic              hit
);
    logic [ADDR_W-3:0] word;
    logic [1:0]        unused_low;

    assign word       = addr[ADDR_W-1:2];
    assign unused_low = addr[1:0];

    always_comb begin
        case (word)
            10'h000: id = RG_GEN0;
            10'h001: id = RG_GEN1;
            10'h003: id = RG_SWITCH;
            10'h004: id = RG_CFG4;
            10'h028: id = RG_RTN;
            10'h029: id = RG_OUT;
            10'h02A: id = RG_CTRL;
            10'h02B: id = RG_STAT;
            10'h040: id = RG_LOCK;
            10'h3FE: id = RG_AUXID;
            10'h3FF: id = RG_ID;
            default: id = RG_NONE;
        endcase
        hit = (id != RG_NONE);
    end
endmodule

// File: rtl/sysctl_osc_bank.sv
module sysctl_osc_bank
    import sysctl_pkg::*;
#(
    parameter int unsigned OSC_COUNT = 3,
    parameter logic [OSC_COUNT-1:0][WORD_W-1:0] OSC_INIT =
        {32'd25_000_000, 32'd24_576_000, 32'd50_000_000},
    localparam int unsigned IDX_W = (OSC_COUNT > 1) ? $clog2(OSC_COUNT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    logic [OSC_COUNT-1:0][WORD_W-1:0] osc_q;

    for (genvar g = 0; g < OSC_COUNT; g++) begin : g_osc
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        osc_q[g] <= OSC_INIT[g];
            else if (we && idx == IDX_W'(g))   osc_q[g] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < OSC_COUNT; i++)
            if (idx == IDX_W'(i)) rdata = osc_q[i];
    end

    // R7
    osc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(osc_q));
endmodule

// File: rtl/sysctl_cfg_chan.sv
module sysctl_cfg_chan
    import sysctl_pkg::*;
#(
    parameter int unsigned OSC_COUNT  = 3,
    parameter int unsigned VALID_FUNC = 1,
    localparam int unsigned IDX_W = (OSC_COUNT > 1) ? $clog2(OSC_COUNT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              out_we,
    input  logic              ctrl_we,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] osc_rdata,
    output logic              osc_we,
    output logic [IDX_W-1:0]  osc_idx,
    output logic [WORD_W-1:0] osc_wdata,
    output logic [WORD_W-1:0] ctrl_q,
    output logic [WORD_W-1:0] stat_word,
    output logic [WORD_W-1:0] rtn_q,
    output logic [WORD_W-1:0] out_q
);
    chan_state_e       state_q, state_d;
    logic [DEV_W-1:0]  dev;
    logic [FUNC_W-1:0] func;
    logic              start_req, txn_ok, rtn_load;

    assign dev       = wdata[DEV_LSB +: DEV_W];
    assign func      = wdata[FUNC_LSB +: FUNC_W];
    assign start_req = ctrl_we && wdata[START_BIT];
    assign txn_ok    = (func == FUNC_W'(VALID_FUNC)) && (dev < DEV_W'(OSC_COUNT));

    // next state: clear, finish, reject
    always_comb begin
        state_d = state_q;
        if (ctrl_we) begin
            if (!wdata[START_BIT]) state_d = CH_IDLE;
            else if (txn_ok)       state_d = CH_DONE;
            else                   state_d = CH_FAULT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        osc_we    = start_req && txn_ok && wdata[WDIR_BIT];
        rtn_load  = start_req && txn_ok && !wdata[WDIR_BIT];
        osc_idx   = dev[IDX_W-1:0];
        osc_wdata = out_q;
        unique case (state_q)
            CH_IDLE:  stat_word = 32'd0;
            CH_DONE:  stat_word = 32'd1;
            CH_FAULT: stat_word = 32'd3;
            default:  stat_word = 32'd0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
            rtn_q  <= '0;
            out_q  <= '0;
        end else begin
            if (ctrl_we)  ctrl_q <= wdata & CTRL_KEEP;
            if (rtn_load) rtn_q  <= osc_rdata;
            if (out_we)   out_q  <= wdata;
        end
    end

    // R6
    chan_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && wdata[START_BIT]) |=> (state_q != CH_IDLE));
    // R5
    chan_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && !wdata[START_BIT]) |=> (state_q == CH_IDLE));
    // R7
    rtn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_req && txn_ok && !wdata[WDIR_BIT]) |=> $stable(rtn_q));
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter logic [31:0] CFG4_VALUE   = 32'h0000_0000,
    parameter logic [31:0] AUX_ID_VALUE = 32'h0000_0000,
    parameter logic [31:0] ID_VALUE     = 32'h0000_0000,
    parameter int unsigned OSC_COUNT    = 3,
    parameter logic [OSC_COUNT-1:0][31:0] OSC_INIT =
        {32'd25_000_000, 32'd24_576_000, 32'd50_000_000},
    parameter int unsigned VALID_FUNC   = 1,
    parameter int unsigned LED_W        = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_write,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_fault,
    output logic [7:0]  led
);
    localparam int unsigned IDX_W = (OSC_COUNT > 1) ? $clog2(OSC_COUNT) : 1;

    reg_id_e           id;
    logic              hit, wr;
    logic [WORD_W-1:0] gen0_q, gen1_q, lock_q;
    logic [WORD_W-1:0] ctrl_q, stat_word, rtn_q, out_q, osc_rdata, osc_wdata;
    logic              osc_we;
    logic [IDX_W-1:0]  osc_idx;

    sysctl_decode u_dec (.addr(bus_addr), .id(id), .hit(hit));

    assign wr = bus_sel && bus_write;

    sysctl_cfg_chan #(.OSC_COUNT(OSC_COUNT), .VALID_FUNC(VALID_FUNC)) u_chan (
        .clk(clk), .rst_n(rst_n),
        .out_we(wr && id == RG_OUT), .ctrl_we(wr && id == RG_CTRL),
        .wdata(bus_wdata), .osc_rdata(osc_rdata),
        .osc_we(osc_we), .osc_idx(osc_idx), .osc_wdata(osc_wdata),
        .ctrl_q(ctrl_q), .stat_word(stat_word), .rtn_q(rtn_q), .out_q(out_q)
    );

    sysctl_osc_bank #(.OSC_COUNT(OSC_COUNT), .OSC_INIT(OSC_INIT)) u_osc (
        .clk(clk), .rst_n(rst_n), .we(osc_we), .idx(osc_idx),
        .wdata(osc_wdata), .rdata(osc_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen0_q <= '0;
            gen1_q <= '0;
            lock_q <= LOCK_RESET;
        end else if (wr) begin
            if (id == RG_GEN0) gen0_q <= bus_wdata;
            if (id == RG_GEN1) gen1_q <= bus_wdata;
            if (id == RG_LOCK)
                lock_q <= (lock_q & ~LOCK_WMASK) | (bus_wdata & LOCK_WMASK);
        end
    end

    always_comb begin
        unique case (id)
            RG_GEN0:  bus_rdata = gen0_q;
            RG_GEN1:  bus_rdata = gen1_q;
            RG_CFG4:  bus_rdata = CFG4_VALUE;
            RG_RTN:   bus_rdata = rtn_q;
            RG_OUT:   bus_rdata = out_q;
            RG_CTRL:  bus_rdata = ctrl_q;
            RG_STAT:  bus_rdata = stat_word;
            RG_LOCK:  bus_rdata = lock_q;
            RG_AUXID: bus_rdata = AUX_ID_VALUE;
            RG_ID:    bus_rdata = ID_VALUE;
            default:  bus_rdata = '0;
        endcase
    end

    assign bus_fault = bus_sel && !hit;
    assign led       = gen1_q[LED_W-1:0];

    // R10
    fault_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_fault && !bus_write) |-> (bus_rdata == '0));
    // R9
    lock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_write && id == RG_LOCK) |-> (bus_rdata[23:0] == 24'hFF0001));
endmodule

// File: tb/sim_sysctl_regs.sv
module sim_sysctl_regs;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] P_CFG4 = 32'h1234_0004;
    localparam logic [31:0] P_AUX  = 32'hA5A5_0FF8;
    localparam logic [31:0] P_ID   = 32'h4D00_0FFC;

    logic        clk = 0, rst_n = 0;
    logic        bus_sel = 0, bus_write = 0;
    logic [11:0] bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        bus_fault;
    logic [7:0]  led;

    int n_run = 0, n_fail = 0;
    logic [31:0] osc_m [3];
    logic [31:0] rtn_m;

    sysctl_regs #(.CFG4_VALUE(P_CFG4), .AUX_ID_VALUE(P_AUX), .ID_VALUE(P_ID)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_fault(bus_fault), .led(led));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d, output logic flt);
        bus_sel = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        #1 flt = bus_fault;
        @(posedge clk); @(negedge clk);
        bus_sel = 0; bus_write = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic flt);
        bus_sel = 1; bus_write = 0; bus_addr = a;
        #1 d = bus_rdata; flt = bus_fault;
        @(posedge clk); @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic rchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d; logic f;
        rd(a, d, f);
        check(tag, d, exp);
    endtask

    task automatic wq(input logic [11:0] a, input logic [31:0] d);
        logic f;
        wr(a, d, f);
    endtask

    function automatic logic [31:0] ctl(input bit start, input bit wdir,
                                        input int func, input int dev);
        return {start, wdir, 4'b0, 6'(func), 8'b0, 12'(dev)};
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d; logic f;
        osc_m[0] = 32'd50_000_000; osc_m[1] = 32'd24_576_000; osc_m[2] = 32'd25_000_000;
        rtn_m = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rchk("R1 ctrl", 12'h0A8, 32'h0010_0000);
        rchk("R1 stat", 12'h0AC, 0);
        rchk("R1 gen0", 12'h000, 0);
        rchk("R1 gen1", 12'h004, 0);
        rchk("R1 rtn",  12'h0A0, 0);
        rchk("R1 out",  12'h0A4, 0);
        rchk("R1 lock", 12'h100, 32'hFFFF_0001);
        check("R1 led", {24'b0, led}, 0);

        // R2 general words, several patterns
        for (int i = 0; i < 8; i++) begin
            logic [31:0] v0, v1;
            v0 = 32'h1 << (i * 4) ^ 32'h5A5A_0000 * i;
            v1 = ~v0 + i;
            wq(12'h000, v0);
            wq(12'h004, v1);
            rchk("R2 gen0", 12'h000, v0);
            rchk("R2 gen1", 12'h004, v1);
            check("R2 led", {24'b0, led}, {24'b0, v1[7:0]});
        end

        // R3 read-only and switch words ignore writes
        wq(12'h00C, 32'hFFFF_FFFF); rchk("R3 switch", 12'h00C, 0);
        wq(12'h010, 32'hFFFF_FFFF); rchk("R3 cfg4",   12'h010, P_CFG4);
        wq(12'hFF8, 32'h0);         rchk("R3 auxid",  12'hFF8, P_AUX);
        wq(12'hFFC, 32'h0);         rchk("R3 id",     12'hFFC, P_ID);

        // R9 lock word
        wq(12'h100, 32'h0000_0000); rchk("R9 lock clr", 12'h100, 32'h00FF_0001);
        wq(12'h100, 32'h3C00_FFFE); rchk("R9 lock mix", 12'h100, 32'h3CFF_0001);

        // R4 field masking (start set, func 63 invalid)
        wq(12'h0A8, 32'hFFFF_FFFF);
        rchk("R4 ctrl mask", 12'h0A8, 32'h43F0_0FFF);
        rchk("R7 stat", 12'h0AC, 3);
        // R5 clear without start
        wq(12'h0A8, 32'h0000_0000);
        rchk("R5 stat clr", 12'h0AC, 0);
        rchk("R4 ctrl zero", 12'h0A8, 0);

        // R6 / R7 / R8 exhaustive read sweep over function codes
        for (int fn = 0; fn < 64; fn++) begin
            for (int k = 0; k < 6; k++) begin
                int dv;
                bit ok;
                dv = (k < 5) ? k : 12'hFFF;
                ok = (fn == 1) && (dv < 3);
                wq(12'h0A8, ctl(1, 0, fn, dv));
                if (ok) rtn_m = osc_m[dv];
                rchk(ok ? "R6 stat rd" : "R7 stat rd", 12'h0AC, ok ? 1 : 3);
                rchk("R8 rtn", 12'h0A0, rtn_m);
                rchk("R4 ctrl rd", 12'h0A8, ctl(0, 0, fn, dv));
            end
        end

        // R8 valid writes
        for (int dv = 0; dv < 3; dv++) begin
            logic [31:0] v;
            v = 32'd1_000_000 * (dv + 7) + 32'd123;
            wq(12'h0A4, v);
            rchk("R2 out rw", 12'h0A4, v);
            wq(12'h0A8, ctl(1, 1, 1, dv));
            osc_m[dv] = v;
            rchk("R6 stat wr", 12'h0AC, 1);
        end
        // R7 invalid writes must not change oscillators
        wq(12'h0A4, 32'hDEAD_BEEF);
        for (int k = 0; k < 6; k++) begin
            int fn, dv;
            fn = (k < 3) ? 1 : k * 9;
            dv = (k < 3) ? 3 + k * 100 : k - 3;
            wq(12'h0A8, ctl(1, 1, fn, dv));
            rchk("R7 stat wr", 12'h0AC, 3);
        end
        // R5 control write without start after fault
        wq(12'h0A8, ctl(0, 1, 1, 0));
        rchk("R5 stat", 12'h0AC, 0);
        for (int dv = 0; dv < 3; dv++) begin
            wq(12'h0A8, ctl(1, 0, 1, dv));
            rchk("R8 osc readback", 12'h0A0, osc_m[dv]);
        end

        // R10 unmapped offsets
        wq(12'h000, 32'h1111_2222);
        wq(12'h004, 32'h3333_4444);
        for (int k = 0; k < 6; k++) begin
            logic [11:0] a;
            a = (k == 0) ? 12'h008 : (k == 1) ? 12'h014 : (k == 2) ? 12'h0B0 :
                (k == 3) ? 12'h104 : (k == 4) ? 12'hFF4 : 12'h800;
            rd(a, d, f);
            check("R10 rd zero", d, 0);
            check("R10 fault rd", {31'b0, f}, 1);
            wr(a, 32'hFFFF_FFFF, f);
            check("R10 fault wr", {31'b0, f}, 1);
        end
        rchk("R10 gen0 kept", 12'h000, 32'h1111_2222);
        rchk("R10 gen1 kept", 12'h004, 32'h3333_4444);
        rchk("R10 lock kept", 12'h100, 32'h3CFF_0001);
        rd(12'h000, d, f);
        check("R10 no fault mapped", {31'b0, f}, 0);
        // low address bits ignored
        rchk("R10 low bits", 12'h003, 32'h1111_2222);
        wq(12'h007, 32'h0000_00A5);
        rchk("R10 low bits wr", 12'h004, 32'h0000_00A5);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule